// File: doc/BRIEF.md
# Packet-Locked Priority Tap Merger

This block gathers traffic from four existing streams without disturbing them and merges it into a single byte-wide valid/ready stream. The usual consumer is a serial debug transmitter. Each input is a passive tap. It sees the valid, ready, data and last signals of a monitored link and records a beat whenever that link completes a transfer. The tap never drives the monitored ready. Captured beats go into a small FIFO for each input.

A two-state controller (idle, writing) picks the lowest-numbered input whose FIFO holds data. It then streams that FIFO to the output until a beat marked last has been accepted. Only after that does it arbitrate again, so a packet always leaves the block whole. If a FIFO is full when its tap sees a beat, the beat is discarded and a sticky overflow flag for that input is raised. The monitored stream is never stalled.

Top module: `tap_merge_top`

## Requirements
- R1: Tap i (i = 0..3) takes its data from bits [8*i+7 : 8*i] of `tapData` and its last marker from `tapLast[i]`. It captures a beat on every clock edge where `tapValid[i]` and `tapReady[i]` are both high. `tapReady` is only an input to the block. A beat captured while the block is idle and empty shows on the output, with `outValid` high, after the second following clock edge.
- R2: A tap whose valid is high while its ready is low captures nothing.
- R3: When idle, the controller grants the lowest-numbered input whose FIFO holds data. Input 0 has the highest priority.
- R4: An input with an empty FIFO is never granted, whatever its priority.
- R5: Once an input is granted, no other input sends a beat until that input's beat with `outLast` high has been accepted, even if a higher-priority input has data waiting.
- R6: Accepting a beat with `outLast` high returns the controller to idle on the next clock. The next grant is chosen afresh by priority.
- R7: While `outValid` is high and `outReady` is low, `outValid`, `outData` and `outLast` hold their values on the next clock.
- R8: A beat captured while its FIFO is full is dropped and sets `overflow[i]`. The flag stays set until reset. Beats already stored are delivered unchanged.
- R9: If the granted FIFO runs empty before the packet's last beat, `outValid` stays low and the grant stays on that input until more of its data arrives.
- R10: A synchronous active-high `rst` empties all FIFOs, clears `overflow` and puts the controller in idle, with `outValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tapValid | input | 4 | Valid of each monitored link |
| tapReady | input | 4 | Ready of each monitored link (observed only) |
| tapLast | input | 4 | Last marker of each monitored link |
| tapData | input | 32 | Data of the monitored links, byte i for tap i |
| outValid | output | 1 | Merged stream valid |
| outReady | input | 1 | Merged stream ready from the consumer |
| outData | output | 8 | Merged stream data byte |
| outLast | output | 1 | Merged stream packet end |
| overflow | output | 4 | Sticky per-input drop flags |

## Verification
The bench builds the block with its defaults: 8-bit data and a FIFO depth of four. The shallow depth means that six back-to-back beats into one tap reach the overflow path. Packets of up to four beats fit fully behind a stalled output, so the bench can set up priority and lock races with `outReady` held low and then release them. This lets the order in which waiting packets leave, the stall-stability window, and the empty-mid-packet gap with a higher-priority input waiting all be observed directly at the ports.

// File: rtl/tap_merge_pkg.sv
package tap_merge_pkg;
  localparam int unsigned NUM_TAPS  = 4;
  localparam int unsigned TAP_IDX_W = $clog2(NUM_TAPS);

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_WRITING = 1'b1
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                 pop;
    logic [TAP_IDX_W-1:0] sel;
  } fifoCtl_t;
endpackage

// File: rtl/tap_fifo.sv
module tap_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pushLast,
  input  logic              pop,
  output logic [DATA_W-1:0] headData,
  output logic              headLast,
  output logic              notEmpty,
  output logic              full
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned ENT_W = DATA_W + 1;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W:0]   wrPtr, rdPtr;

  assign notEmpty = (wrPtr != rdPtr);
  assign full     = (wrPtr[PTR_W] != rdPtr[PTR_W]) &&
                    (wrPtr[PTR_W-1:0] == rdPtr[PTR_W-1:0]);
  assign {headLast, headData} = mem[rdPtr[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr[PTR_W-1:0]] <= {pushLast, pushData};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  // R4: the controller must never pull from an empty buffer
  p_pop_has_data_r4: assert property (@(posedge clk) disable iff (rst)
    pop |-> notEmpty);
  // R8: a write never lands on a full buffer
  p_push_has_room_r8: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
endmodule

// File: rtl/tap_merge_datapath.sv
module tap_merge_datapath
  import tap_merge_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_TAPS-1:0]          tapValid,
  input  logic [NUM_TAPS-1:0]          tapReady,
  input  logic [NUM_TAPS-1:0]          tapLast,
  input  logic [NUM_TAPS*DATA_W-1:0]   tapData,
  input  fifoCtl_t                     ctl,
  output logic [NUM_TAPS-1:0]          notEmpty,
  output logic [DATA_W-1:0]            headData,
  output logic                         headLast,
  output logic [NUM_TAPS-1:0]          overflow
);
  logic [DATA_W-1:0] headDataArr [NUM_TAPS];
  logic [NUM_TAPS-1:0] headLastArr;
  logic [NUM_TAPS-1:0] fifoFull;
  logic [NUM_TAPS-1:0] captured;
  logic [NUM_TAPS-1:0] pushEn;

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    logic popEn;
    assign captured[i] = tapValid[i] & tapReady[i];
    assign pushEn[i]   = captured[i] & ~fifoFull[i];
    assign popEn       = ctl.pop && (ctl.sel == TAP_IDX_W'(i));

    tap_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .push     (pushEn[i]),
      .pushData (tapData[i*DATA_W +: DATA_W]),
      .pushLast (tapLast[i]),
      .pop      (popEn),
      .headData (headDataArr[i]),
      .headLast (headLastArr[i]),
      .notEmpty (notEmpty[i]),
      .full     (fifoFull[i])
    );

    always_ff @(posedge clk) begin
      if (rst)                            overflow[i] <= 1'b0;
      else if (captured[i] & fifoFull[i]) overflow[i] <= 1'b1;
    end

    // R8: once raised, a drop flag stays up until reset
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      overflow[i] |=> overflow[i]);
  end

  assign headData = headDataArr[ctl.sel];
  assign headLast = headLastArr[ctl.sel];
endmodule

// File: rtl/tap_merge_control.sv
module tap_merge_control
  import tap_merge_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TAPS-1:0] notEmpty,
  input  logic                headLast,
  input  logic                outReady,
  output logic                outValid,
  output fifoCtl_t            ctl
);
  arbState_t            state;
  logic [TAP_IDX_W-1:0] grant;
  logic [TAP_IDX_W-1:0] pick;
  logic                 anyReq;
  logic                 xfer;

  always_comb begin
    pick = '0;
    for (int i = NUM_TAPS - 1; i >= 0; i--) begin
      if (notEmpty[i]) pick = TAP_IDX_W'(i);
    end
  end

  assign anyReq   = |notEmpty;
  assign outValid = (state == ST_WRITING) && notEmpty[grant];
  assign xfer     = outValid && outReady;
  assign ctl.pop  = xfer;
  assign ctl.sel  = grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      grant <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (anyReq) begin
          grant <= pick;
          state <= ST_WRITING;
        end
        ST_WRITING: if (xfer && headLast) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a waiting top-priority input wins the next idle decision
  p_top_priority_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && notEmpty[0]) |=> (state == ST_WRITING && grant == '0));
  // R5: the grant does not move while a packet is open
  p_grant_locked_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRITING && !(xfer && headLast)) |=>
      (state == ST_WRITING && $stable(grant)));
  // R6: an accepted last beat closes the packet
  p_last_to_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (xfer && headLast) |=> (state == ST_IDLE));
endmodule

// File: rtl/tap_merge_top.sv
module tap_merge_top
  import tap_merge_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_TAPS-1:0]        tapValid,
  input  logic [NUM_TAPS-1:0]        tapReady,
  input  logic [NUM_TAPS-1:0]        tapLast,
  input  logic [NUM_TAPS*DATA_W-1:0] tapData,
  output logic                       outValid,
  input  logic                       outReady,
  output logic [DATA_W-1:0]          outData,
  output logic                       outLast,
  output logic [NUM_TAPS-1:0]        overflow
);
  fifoCtl_t            ctl;
  logic [NUM_TAPS-1:0] notEmpty;

  tap_merge_datapath #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .tapValid (tapValid),
    .tapReady (tapReady),
    .tapLast  (tapLast),
    .tapData  (tapData),
    .ctl      (ctl),
    .notEmpty (notEmpty),
    .headData (outData),
    .headLast (outLast),
    .overflow (overflow)
  );

  tap_merge_control u_ctl (
    .clk      (clk),
    .rst      (rst),
    .notEmpty (notEmpty),
    .headLast (outLast),
    .outReady (outReady),
    .outValid (outValid),
    .ctl      (ctl)
  );

  // R7: an offered beat is held unchanged until taken
  p_hold_stalled_r7: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));
endmodule

// File: tb/tap_merge_top_test.sv
`timescale 1ns/1ps
module tap_merge_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  tapValid = '0, tapReady = '0, tapLast = '0;
  logic [31:0] tapData = '0;
  logic        outValid, outReady = 1'b0, outLast;
  logic [7:0]  outData;
  logic [3:0]  overflow;

  int total = 0, bad = 0;
  logic [7:0] gotData [64];
  logic       gotLast [64];
  int         gotCnt;

  always #2.5 clk = ~clk;

  tap_merge_top uut (
    .clk(clk), .rst(rst), .tapValid(tapValid), .tapReady(tapReady),
    .tapLast(tapLast), .tapData(tapData), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outLast(outLast),
    .overflow(overflow)
  );

  function automatic logic [7:0] mk(input int tap, input int seq);
    return 8'(tap * 16 + seq);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of tap activity (set at negedge, captured next posedge)
  task automatic put(input logic [3:0] v, input logic [3:0] r,
                     input logic [3:0] l, input logic [31:0] d);
    @(negedge clk);
    tapValid = v; tapReady = r; tapLast = l; tapData = d;
  endtask

  task automatic quiet();
    @(negedge clk);
    tapValid = '0; tapReady = '0; tapLast = '0; tapData = '0;
  endtask

  task automatic waitCyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic drain(input int n);
    int guard;
    gotCnt = 0; guard = 0;
    @(negedge clk);
    outReady = 1'b1;
    while (gotCnt < n && guard < 300) begin
      if (outValid) begin
        gotData[gotCnt] = outData;
        gotLast[gotCnt] = outLast;
        gotCnt++;
      end
      guard++;
      if (gotCnt < n) @(negedge clk);
    end
    @(posedge clk);
    #1 outReady = 1'b0;
    check(gotCnt == n, "drain count", gotCnt, n);
  endtask

  task automatic expBeat(input int idx, input logic [7:0] d, input logic l, input string req);
    check(gotData[idx] == d, req, gotData[idx], d);
    check(gotLast[idx] == l, {req, " last"}, gotLast[idx], l);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic testReset();
    check(outValid == 1'b0, "R10 reset valid", outValid, 0);
    check(overflow == 4'b0, "R10 reset overflow", overflow, 0);
  endtask

  task automatic testLatency();
    put(4'b0100, 4'b0100, 4'b0100, {8'h0, mk(2, 0), 16'h0});
    quiet();                                     // capture edge passed
    check(outValid == 1'b0, "R1 one edge after capture", outValid, 0);
    @(negedge clk);
    check(outValid == 1'b1, "R1 two edges after capture", outValid, 1);
    check(outData == mk(2, 0), "R1 tap2 byte lane", outData, mk(2, 0));
    drain(1);
    expBeat(0, mk(2, 0), 1'b1, "R1 single beat");
  endtask

  task automatic testPriority();
    put(4'b1011, 4'b1011, 4'b0010, {mk(3, 0), 8'h0, mk(1, 0), mk(0, 0)});
    put(4'b1001, 4'b1001, 4'b0001, {mk(3, 1), 8'h0, 8'h0, mk(0, 1)});
    put(4'b1000, 4'b1000, 4'b1000, {mk(3, 2), 24'h0});
    quiet();
    waitCyc(2);
    check(outValid == 1'b1, "R7 stalled valid", outValid, 1);
    check(outData == mk(0, 0), "R3 input0 first", outData, mk(0, 0));
    waitCyc(3);
    check(outValid == 1'b1, "R7 valid held", outValid, 1);
    check(outData == mk(0, 0), "R7 data held", outData, mk(0, 0));
    drain(6);
    expBeat(0, mk(0, 0), 1'b0, "R3 order");
    expBeat(1, mk(0, 1), 1'b1, "R3 order");
    expBeat(2, mk(1, 0), 1'b1, "R6 rearbitrate to input1");
    expBeat(3, mk(3, 0), 1'b0, "R4 empty input2 skipped");
    expBeat(4, mk(3, 1), 1'b0, "R3 order");
    expBeat(5, mk(3, 2), 1'b1, "R3 order");
  endtask

  task automatic testLock();
    put(4'b0100, 4'b0100, 4'b0000, {8'h0, mk(2, 0), 16'h0});
    put(4'b0101, 4'b0101, 4'b0001, {8'h0, mk(2, 1), 8'h0, mk(0, 5)});
    put(4'b0100, 4'b0100, 4'b0100, {8'h0, mk(2, 2), 16'h0});
    quiet();
    waitCyc(2);
    drain(4);
    expBeat(0, mk(2, 0), 1'b0, "R5 lock");
    expBeat(1, mk(2, 1), 1'b0, "R5 lock");
    expBeat(2, mk(2, 2), 1'b1, "R5 lock");
    expBeat(3, mk(0, 5), 1'b1, "R5 waiting input0 after");
  endtask

  task automatic testStarve();
    put(4'b0010, 4'b0010, 4'b0000, {16'h0, mk(1, 0), 8'h0});
    quiet();
    drain(1);
    expBeat(0, mk(1, 0), 1'b0, "R9 first beat");
    put(4'b0001, 4'b0001, 4'b0001, {24'h0, mk(0, 7)});
    quiet();
    outReady = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R9 gap valid low", outValid, 0);
    end
    outReady = 1'b0;
    put(4'b0010, 4'b0010, 4'b0010, {16'h0, mk(1, 1), 8'h0});
    quiet();
    drain(2);
    expBeat(0, mk(1, 1), 1'b1, "R9 same input resumes");
    expBeat(1, mk(0, 7), 1'b1, "R9 then input0");
  endtask

  task automatic testOverflow();
    for (int s = 0; s < 6; s++)
      put(4'b1000, 4'b1000, (s == 3 || s == 5) ? 4'b1000 : 4'b0000, {mk(3, s), 24'h0});
    quiet();
    @(negedge clk);
    check(overflow == 4'b1000, "R8 sticky flag", overflow, 4'b1000);
    drain(4);
    for (int s = 0; s < 4; s++) expBeat(s, mk(3, s), s == 3, "R8 kept beats");
    waitCyc(4);
    check(outValid == 1'b0, "R8 dropped beats absent", outValid, 0);
    check(overflow == 4'b1000, "R8 flag still set", overflow, 4'b1000);
    doReset();
    check(overflow == 4'b0, "R10 reset clears flag", overflow, 0);
  endtask

  task automatic testIgnore();
    put(4'b1111, 4'b0000, 4'b1111, 32'hA5A5A5A5);
    put(4'b1111, 4'b0000, 4'b1111, 32'h5A5A5A5A);
    quiet();
    outReady = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R2 no capture without ready", outValid, 0);
    end
    outReady = 1'b0;
  endtask

  task automatic testResetFlush();
    put(4'b0001, 4'b0001, 4'b0000, {24'h0, mk(0, 1)});
    quiet();
    doReset();
    waitCyc(3);
    check(outValid == 1'b0, "R10 reset empties fifo", outValid, 0);
  endtask

  initial begin
    waitCyc(3);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testLatency();
    testPriority();
    testLock();
    testStarve();
    testOverflow();
    testIgnore();
    testResetFlush();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule